// File: doc/BRIEF.md
# PHY Control Register Bank with Per-Bit Write Enables

This block holds the static control state of a camera-side PHY receiver: which lanes are enabled, the per-lane force-receive, force-stop and turnaround-disable controls, the turnaround request, and the serial test-port pins (data in, enable, clock, clear). Software reaches it through a plain address / write-strobe / write-data / read-data port. The field values are driven straight out as wires to the PHY. The 8-bit test-data-out value that the PHY returns can be read back through the same port.

Every write word has two halves. The low 16 bits carry new bit values. The high 16 bits are per-bit enables: bit 16+i lets bit i change. A driver can therefore change one field, or even toggle the test clock alone, in a single write, without first reading the register back. Only the low half is stored. A read of a control register shows the stored half with zeros above it.

Top module: `phy_ctl_bank`

## Requirements
- R1: While rst_n is low at a clock edge, every control register clears to zero, and so does every PHY-facing output.
- R2: On a write to a control register, each bit i (0..15) whose enable bit wdata[16+i] is 1 takes the value wdata[i] at that clock edge.
- R3: On a write, each bit whose enable bit is 0 keeps its value. A write whose upper half is all zero changes nothing.
- R4: Reading a control register (addresses 0..2) returns 16 zero bits above the 16 stored bits. The read data is combinational from addr.
- R5: Address 0 is the lane register. Bits 3:0 drive lane_en, bits 7:4 drive force_rx, bits 11:8 drive force_stop and bits 15:12 drive turn_dis.
- R6: Address 1 is the turnaround register. Bits 3:0 drive turn_req. Bits 15:4 are stored and readable but drive no output.
- R7: Address 2 is the test register. Bits 7:0 drive test_din, bit 8 drives test_en, bit 9 drives test_clk and bit 10 drives test_clr. Bits 15:11 are stored and readable.
- R8: Address 3 is read-only. A read returns test_dout in bits 7:0 and zero above. A write there changes no register.
- R9: Addresses 4..7 are unmapped. They read as zero, and writes to them change no register.
- R10: When wr_en is low, no register changes, whatever addr and wdata hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write strobe for the addressed register |
| addr | input | 3 | Register address |
| wdata | input | 32 | Write word: enables in 31:16, values in 15:0 |
| rdata | output | 32 | Read word for addr |
| lane_en | output | 4 | Lane enables |
| force_rx | output | 4 | Per-lane force-receive mode |
| force_stop | output | 4 | Per-lane force-stop mode |
| turn_dis | output | 4 | Per-lane turnaround disable |
| turn_req | output | 4 | Per-lane turnaround request |
| test_din | output | 8 | Test port data in |
| test_en | output | 1 | Test port enable |
| test_clk | output | 1 | Test port clock |
| test_clr | output | 1 | Test port clear |
| test_dout | input | 8 | Test port data out from the PHY |

## Verification
The bench targets these corner cases, each with the failure it would expose:
- A partial enable mask that clears one field inside a populated register. A design that loads the whole low half would wipe the neighbouring fields.
- An all-zero mask. A design that ignores the enables would overwrite the register.
- Writes to the read-only address, to unmapped addresses, and with the strobe low. A loose address decode would alias those writes onto the control registers.
- The field-to-pin mapping and the zero upper read half. A swapped nibble or a leaked enable half shows up directly on the pins or in rdata.

// File: rtl/ctlbank_pkg.sv
// Package: shared widths, register addresses and field layouts for the PHY
// control register bank. Assumes a 32-bit write word with a 16-bit stored half.
package ctlbank_pkg;
    localparam int WORD_W    = 32;
    localparam int HALF_W    = WORD_W / 2;
    localparam int LANES     = 4;
    localparam int TDATA_W   = 8;
    localparam int NUM_CTRL  = 3;
    localparam int ADDR_LANE = 0;
    localparam int ADDR_TURN = 1;
    localparam int ADDR_TEST = 2;
    localparam int ADDR_STAT = 3;
    localparam int NUM_MAPPED = ADDR_STAT + 1;

    // Lane register layout, MSB first.
    typedef struct packed {
        logic [LANES-1:0] turn_dis;
        logic [LANES-1:0] force_stop;
        logic [LANES-1:0] force_rx;
        logic [LANES-1:0] lane_en;
    } lane_ctl_t;

    // Test register layout, MSB first.
    typedef struct packed {
        logic [HALF_W-TDATA_W-4:0] spare;
        logic                      clr;
        logic                      tclk;
        logic                      en;
        logic [TDATA_W-1:0]        din;
    } test_ctl_t;
endpackage

// File: rtl/hw_mask_reg.sv
// Module: hw_mask_reg
// One stored half-word whose bits update individually under a per-bit enable.
// Assumes: the caller has already split the write word into values and enables.
module hw_mask_reg #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  logic [W-1:0] val,
    input  logic [W-1:0] msk,
    output logic [W-1:0] q
);
    logic [W-1:0] nxt;

    // Merge: enabled bits take the new value, the rest keep the old one.
    always_comb begin
        nxt = (q & ~msk) | (val & msk);
    end

    // State: synchronous clear, else load the merged word on a write.
    always_ff @(posedge clk) begin
        if (!rst_n)  q <= '0;
        else if (we) q <= nxt;
    end

    AST_RESET_ZERO: assert property (@(posedge clk) !rst_n |=> q == '0); // R1
    AST_MASKED_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (q & $past(msk)) == ($past(val) & $past(msk))); // R2
    AST_UNMASKED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (q & ~$past(msk)) == ($past(q) & ~$past(msk))); // R3
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(q)); // R10
endmodule

// File: rtl/ctl_read_mux.sv
// Module: ctl_read_mux
// Selects the read word: the control registers zero-extended, the status byte,
// or zero for unmapped addresses. Assumes: control registers occupy addresses 0..NUM_CTRL-1.
module ctl_read_mux
    import ctlbank_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [ADDR_W-1:0]                addr,
    input  logic [NUM_CTRL-1:0][HALF_W-1:0]  ctl,
    input  logic [TDATA_W-1:0]               status,
    output logic [WORD_W-1:0]                rdata
);
    // Decode: the address picks the source, and zero is the default.
    always_comb begin
        rdata = '0;
        if (int'(addr) < NUM_CTRL)
            rdata = {{(WORD_W-HALF_W){1'b0}}, ctl[addr[$clog2(NUM_CTRL)-1:0]]};
        else if (int'(addr) == ADDR_STAT)
            rdata = {{(WORD_W-TDATA_W){1'b0}}, status};
    end

    AST_CTRL_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(addr) < NUM_CTRL) |-> rdata[WORD_W-1:HALF_W] == '0); // R4
    AST_UNMAPPED_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(addr) >= NUM_MAPPED) |-> rdata == '0); // R9
endmodule

// File: rtl/phy_ctl_bank.sv
// Module: phy_ctl_bank (top)
// Bank of three half-word write-masked control registers plus one read-only
// status byte. Fields go out as plain wires to the PHY.
// Assumes: a single-cycle write strobe and a combinational read.
module phy_ctl_bank
    import ctlbank_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [WORD_W-1:0]   wdata,
    output logic [WORD_W-1:0]   rdata,
    output logic [LANES-1:0]    lane_en,
    output logic [LANES-1:0]    force_rx,
    output logic [LANES-1:0]    force_stop,
    output logic [LANES-1:0]    turn_dis,
    output logic [LANES-1:0]    turn_req,
    output logic [TDATA_W-1:0]  test_din,
    output logic                test_en,
    output logic                test_clk,
    output logic                test_clr,
    input  logic [TDATA_W-1:0]  test_dout
);
    logic [NUM_CTRL-1:0][HALF_W-1:0] ctl_q;
    logic [HALF_W-1:0]               wr_val;
    logic [HALF_W-1:0]               wr_msk;
    lane_ctl_t                       lane_f;
    test_ctl_t                       test_f;

    // Split: value half and enable half of the write word.
    always_comb begin
        wr_val = wdata[HALF_W-1:0];
        wr_msk = wdata[WORD_W-1:HALF_W];
    end

    // One masked register per control address, each with its own write decode.
    for (genvar g = 0; g < NUM_CTRL; g++) begin : g_reg
        logic sel_we;
        always_comb sel_we = wr_en && (int'(addr) == g);
        hw_mask_reg #(.W(HALF_W)) i_reg (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (sel_we),
            .val   (wr_val),
            .msk   (wr_msk),
            .q     (ctl_q[g])
        );
    end

    ctl_read_mux #(.ADDR_W(ADDR_W)) i_rmux (
        .clk    (clk),
        .rst_n  (rst_n),
        .addr   (addr),
        .ctl    (ctl_q),
        .status (test_dout),
        .rdata  (rdata)
    );

    // Field fan-out: stored bits to PHY-facing wires.
    always_comb begin
        lane_f     = lane_ctl_t'(ctl_q[ADDR_LANE]);
        test_f     = test_ctl_t'(ctl_q[ADDR_TEST]);
        lane_en    = lane_f.lane_en;
        force_rx   = lane_f.force_rx;
        force_stop = lane_f.force_stop;
        turn_dis   = lane_f.turn_dis;
        turn_req   = ctl_q[ADDR_TURN][LANES-1:0];
        test_din   = test_f.din;
        test_en    = test_f.en;
        test_clk   = test_f.tclk;
        test_clr   = test_f.clr;
    end

    AST_STATUS_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && int'(addr) == ADDR_STAT) |=> $stable(ctl_q)); // R8
    AST_UNMAPPED_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && int'(addr) >= NUM_MAPPED) |=> $stable(ctl_q)); // R9
    AST_NO_STROBE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(ctl_q)); // R10
endmodule

// File: tb/test_phy_ctl_bank.sv
// Bench for phy_ctl_bank: a vector table of write-then-read steps, then directed tests.
module test_phy_ctl_bank;
    localparam time CLK_PERIOD = 10ns;
    localparam int  NVEC = 9;
    // Entry layout: {addr[2:0], wdata[31:0], expected read of same addr[31:0]}
    localparam logic [66:0] VEC [NVEC] = '{
        {3'd0, 32'hFFFF_A5C3, 32'h0000_A5C3},  // R2 full load
        {3'd0, 32'h00F0_0000, 32'h0000_A503},  // R3 clear only bits 7:4
        {3'd0, 32'h0000_FFFF, 32'h0000_A503},  // R3 zero mask
        {3'd1, 32'h000F_0005, 32'h0000_0005},  // R6
        {3'd1, 32'hFFF0_1234, 32'h0000_1235},  // R6 upper bits stored
        {3'd2, 32'h07FF_0155, 32'h0000_0155},  // R7
        {3'd2, 32'h0200_0200, 32'h0000_0355},  // R7 test clock alone
        {3'd3, 32'hFFFF_FFFF, 32'h0000_003C},  // R8 status read-only
        {3'd5, 32'hFFFF_FFFF, 32'h0000_0000}   // R9 unmapped
    };

    logic        clk = 0;
    logic        rst_n = 0;
    logic        wr_en = 0;
    logic [2:0]  addr = 0;
    logic [31:0] wdata = 0;
    logic [31:0] rdata;
    logic [3:0]  lane_en, force_rx, force_stop, turn_dis, turn_req;
    logic [7:0]  test_din;
    logic        test_en, test_clk, test_clr;
    logic [7:0]  test_dout = 8'h3C;
    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    phy_ctl_bank i_phy_ctl_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .lane_en(lane_en), .force_rx(force_rx),
        .force_stop(force_stop), .turn_dis(turn_dis), .turn_req(turn_req),
        .test_din(test_din), .test_en(test_en), .test_clk(test_clk),
        .test_clr(test_clr), .test_dout(test_dout)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d, input logic strobe);
        @(negedge clk);
        addr = a; wdata = d; wr_en = strobe;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic rd_chk(input string req, input logic [2:0] a, input logic [31:0] exp);
        addr = a;
        #1;
        chk(req, rdata, exp);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual hung expected done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state of registers and pins
        rd_chk("R1 reg0", 3'd0, 32'h0);
        rd_chk("R1 reg1", 3'd1, 32'h0);
        rd_chk("R1 reg2", 3'd2, 32'h0);
        chk("R1 pins", {lane_en, force_rx, force_stop, turn_dis, turn_req,
                        test_din, test_en, test_clk, test_clr}, 32'h0);
        rst_n = 1;
        @(negedge clk);

        for (int i = 0; i < NVEC; i++) begin
            wr(VEC[i][66:64], VEC[i][63:32], 1'b1);
            rd_chk($sformatf("R2/R3/R4 vec%0d", i), VEC[i][66:64], VEC[i][31:0]);
        end

        // R5: lane field mapping (reg0 = A503)
        chk("R5 lane_en", 32'(lane_en), 32'h3);
        chk("R5 force_rx", 32'(force_rx), 32'h0);
        chk("R5 force_stop", 32'(force_stop), 32'h5);
        chk("R5 turn_dis", 32'(turn_dis), 32'hA);
        // R6: turn_req (reg1 = 1235)
        chk("R6 turn_req", 32'(turn_req), 32'h5);
        // R7: test fields (reg2 = 0355)
        chk("R7 test_din", 32'(test_din), 32'h55);
        chk("R7 test_en/clk/clr", {29'h0, test_clr, test_clk, test_en}, 32'h3);
        // R8, R9: status and unmapped writes touched nothing
        rd_chk("R9 reg0 after unmapped wr", 3'd0, 32'h0000_A503);
        rd_chk("R9 reg1 after unmapped wr", 3'd1, 32'h0000_1235);
        rd_chk("R9 reg2 after unmapped wr", 3'd2, 32'h0000_0355);
        rd_chk("R9 read addr7", 3'd7, 32'h0);
        test_dout = 8'h81;
        rd_chk("R8 status follows input", 3'd3, 32'h0000_0081);
        // R10: strobe low has no effect
        wr(3'd0, 32'hFFFF_0000, 1'b0);
        rd_chk("R10 reg0 unchanged", 3'd0, 32'h0000_A503);
        chk("R10 lane_en unchanged", 32'(lane_en), 32'h3);
        // R2: single-bit clear of test_clk
        wr(3'd2, 32'h0200_0000, 1'b1);
        chk("R2 test_clk cleared", 32'(test_clk), 32'h0);
        rd_chk("R2 reg2 after clk clear", 3'd2, 32'h0000_0155);
        // R1: reset again clears all
        @(negedge clk);
        rst_n = 0;
        @(negedge clk);
        rd_chk("R1 reg0 after reset", 3'd0, 32'h0);
        rd_chk("R1 reg2 after reset", 3'd2, 32'h0);
        chk("R1 pins after reset", {lane_en, force_rx, force_stop, turn_dis, turn_req,
                                    test_din, test_en, test_clk, test_clr}, 32'h0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule